// File: doc/BRIEF.md
# Reciprocal estimate unit

This unit returns a reciprocal estimate with eight fraction bits of accuracy. The operand is either a single-precision float or an unsigned 32-bit fixed-point number whose binary point sits just above bit 31. A mode input selects which. The estimate comes from a 256-entry function of the top significand bits. The entry for index `i` is the rounded reciprocal of the midpoint of the interval that `i` selects. A parameter picks how it is built: as a table filled at elaboration, or as a combinational divider.

In float mode the unit also sorts out the operand classes that have no ordinary estimate. NaNs are propagated, or replaced by the default NaN. Zero and subnormal operands become infinities. Infinities become zeros. Operands too large for a normal reciprocal collapse to a signed zero. Three flags go with each result: invalid, divide-by-zero and underflow. One operand is accepted per cycle. The result, the flags and a valid strobe appear one clock later.

Top module: `recip_est_unit`

## Requirements
- R1: `outValid` is high exactly in the cycle after a cycle with `inValid` high. `result` and the three flags change only in that cycle and hold their value otherwise.
- R2: In float mode, a normal operand with biased exponent `e` from 1 to 252 gives the following result:
  - sign: the operand's sign.
  - exponent field: `253 - e`.
  - fraction: `{s[7:0], 15'b0}`, where `q = 256 + operand[22:15]` and `s = round(256 * 512 / (q + 0.5))`, a value from 256 to 511.
  - flags: none raised.
- R3: In float mode, an operand with biased exponent 253 or 254 gives a zero of the operand's sign and raises only `flagUnderflow`.
- R4: In float mode, an operand with exponent field 0 (zero or subnormal) gives `{sign, 8'hFF, 23'b0}` and raises only `flagDivZero`.
- R5: In float mode, an infinity (exponent 0xFF, fraction 0) gives a zero of the same sign and raises no flag.
- R6: In float mode with `defaultNan` low, a NaN operand returns the operand with bit 22 set. `flagInvalid` is raised exactly when bit 22 of the operand was clear (a signaling NaN).
- R7: In float mode with `defaultNan` high, a NaN operand returns 0x7FC00000. `flagInvalid` is raised exactly for a signaling NaN.
- R8: In fixed mode, an operand with bit 31 clear returns 0xFFFFFFFF with no flag.
- R9: In fixed mode, an operand with bit 31 set returns `{1'b1, s[7:0], 23'b0}` with no flag. Here `s` is the R2 formula with `q = operand[31:23]`.
- R10: At most one of the three flags is high at any time.
- R11: During and right after reset, `outValid`, `result` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand present this cycle |
| fixedMode | input | 1 | 1: unsigned fixed-point operand, 0: single-precision float |
| defaultNan | input | 1 | 1: any NaN result is 0x7FC00000 |
| operand | input | 32 | Operand bits |
| outValid | output | 1 | Result present this cycle |
| result | output | 32 | Estimate or special value |
| flagInvalid | output | 1 | Signaling NaN seen |
| flagDivZero | output | 1 | Zero or subnormal operand |
| flagUnderflow | output | 1 | Operand too large, result flushed to zero |

## Verification
A wrong table entry shows up as a wrong fraction byte. It appears one cycle after that index is presented, and for that index only. The bench therefore presents every index in both modes and at several exponents. A misclassified operand shows up in the same cycle as a wrong special pattern or a wrong flag. The boundary exponents 0, 1, 252, 253, 254 and 255, and both kinds of NaN under both NaN modes, are each presented. A fault in the capture strobe appears as a result that moves while `outValid` is low, or as a valid strobe that is offset by a cycle.

// File: rtl/recip_est_pkg.sv
package recip_est_pkg;

  localparam int FLT_W  = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int QUIET_BIT = 22;

  localparam logic [EXP_W-1:0] EXP_MAX     = 8'hFF;
  localparam logic [EXP_W-1:0] EXP_HUGE    = 8'd253;
  localparam logic [EXP_W-1:0] EXP_MIRROR  = 8'd253;
  localparam logic [FLT_W-1:0] NAN_DEFAULT = 32'h7FC0_0000;

  // Which result pattern the datapath builds.
  typedef enum logic [2:0] {
    CASE_EST_FLT,
    CASE_NAN_PROP,
    CASE_NAN_DEF,
    CASE_SIGNED_ZERO,
    CASE_SIGNED_INF,
    CASE_EST_FIX,
    CASE_FIX_SAT
  } caseSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     load;
    caseSel_e caseSel;
    logic     raiseInvalid;
    logic     raiseDivZero;
    logic     raiseUnderflow;
  } strobes_t;

  // Rounded reciprocal of the midpoint of interval idx, scaled by 2^idxBits.
  function automatic int unsigned estEntry(int idxBits, int idx);
    int unsigned q;
    int unsigned den;
    int unsigned num;
    q   = (32'd1 << idxBits) + idx;
    den = 2 * q + 1;
    num = 32'd1 << (2 * idxBits + 3);
    return (num + den) / (2 * den);
  endfunction

endpackage

// File: rtl/recip_est_table.sv
module recip_est_table #(
  parameter int IDX_BITS  = 8,
  parameter bit USE_TABLE = 1'b1
) (
  input  logic [IDX_BITS-1:0] idx,
  output logic [IDX_BITS-1:0] est
);
  import recip_est_pkg::*;

  localparam int DEPTH = 1 << IDX_BITS;
  localparam int NUM_W = 2 * IDX_BITS + 5;

  generate
    if (USE_TABLE) begin : g_table
      logic [IDX_BITS-1:0] entries [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam int unsigned S = estEntry(IDX_BITS, i);
        assign entries[i] = S[IDX_BITS-1:0];
      end
      assign est = entries[idx];
    end else begin : g_logic
      localparam logic [NUM_W-1:0] TOP = NUM_W'(1) << (2 * IDX_BITS + 3);
      logic [NUM_W-1:0] den;
      logic [NUM_W-1:0] quo;
      always_comb begin
        den = NUM_W'({1'b1, idx, 1'b1});
        quo = (TOP + den) / (den << 1);
        est = quo[IDX_BITS-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/recip_est_ctrl.sv
module recip_est_ctrl (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            inValid,
  input  logic                            fixedMode,
  input  logic                            defaultNan,
  input  logic [recip_est_pkg::FLT_W-1:0] operand,
  output recip_est_pkg::strobes_t         strobes,
  output logic                            outValid
);
  import recip_est_pkg::*;

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;

  assign expField  = operand[FLT_W-2 -: EXP_W];
  assign fracField = operand[FRAC_W-1:0];

  always_comb begin
    strobes         = '0;
    strobes.load    = inValid;
    strobes.caseSel = CASE_EST_FLT;
    if (fixedMode) begin
      strobes.caseSel = operand[FLT_W-1] ? CASE_EST_FIX : CASE_FIX_SAT;
    end else if (expField == EXP_MAX) begin
      if (fracField != '0) begin
        strobes.caseSel      = defaultNan ? CASE_NAN_DEF : CASE_NAN_PROP;
        strobes.raiseInvalid = ~fracField[QUIET_BIT];
      end else begin
        strobes.caseSel = CASE_SIGNED_ZERO;
      end
    end else if (expField == '0) begin
      strobes.caseSel      = CASE_SIGNED_INF;
      strobes.raiseDivZero = 1'b1;
    end else if (expField >= EXP_HUGE) begin
      strobes.caseSel        = CASE_SIGNED_ZERO;
      strobes.raiseUnderflow = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/recip_est_dp.sv
module recip_est_dp #(
  parameter int IDX_BITS  = 8,
  parameter bit USE_TABLE = 1'b1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  recip_est_pkg::strobes_t         strobes,
  input  logic [recip_est_pkg::FLT_W-1:0] operand,
  output logic [recip_est_pkg::FLT_W-1:0] result,
  output logic                            flagInvalid,
  output logic                            flagDivZero,
  output logic                            flagUnderflow
);
  import recip_est_pkg::*;

  localparam int FLT_PAD = FRAC_W - IDX_BITS;
  localparam int FIX_PAD = FLT_W - 1 - IDX_BITS;

  logic [IDX_BITS-1:0] idx;
  logic [IDX_BITS-1:0] est;
  logic [FLT_W-1:0]    nextResult;
  logic                sgn;
  logic [EXP_W-1:0]    expField;

  assign sgn      = operand[FLT_W-1];
  assign expField = operand[FLT_W-2 -: EXP_W];
  assign idx = (strobes.caseSel == CASE_EST_FIX) ? operand[FLT_W-2 -: IDX_BITS]
                                                 : operand[FRAC_W-1 -: IDX_BITS];

  recip_est_table #(.IDX_BITS(IDX_BITS), .USE_TABLE(USE_TABLE)) u_table (
    .idx (idx),
    .est (est)
  );

  always_comb begin
    unique case (strobes.caseSel)
      CASE_EST_FLT:     nextResult = {sgn, EXP_MIRROR - expField, est, {FLT_PAD{1'b0}}};
      CASE_NAN_PROP:    nextResult = operand | (FLT_W'(1) << QUIET_BIT);
      CASE_NAN_DEF:     nextResult = NAN_DEFAULT;
      CASE_SIGNED_ZERO: nextResult = {sgn, {(FLT_W-1){1'b0}}};
      CASE_SIGNED_INF:  nextResult = {sgn, EXP_MAX, {FRAC_W{1'b0}}};
      CASE_EST_FIX:     nextResult = {1'b1, est, {FIX_PAD{1'b0}}};
      CASE_FIX_SAT:     nextResult = '1;
      default:          nextResult = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result        <= '0;
      flagInvalid   <= 1'b0;
      flagDivZero   <= 1'b0;
      flagUnderflow <= 1'b0;
    end else if (strobes.load) begin
      result        <= nextResult;
      flagInvalid   <= strobes.raiseInvalid;
      flagDivZero   <= strobes.raiseDivZero;
      flagUnderflow <= strobes.raiseUnderflow;
    end
  end

endmodule

// File: rtl/recip_est_unit.sv
module recip_est_unit #(
  parameter int IDX_BITS  = 8,
  parameter bit USE_TABLE = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        fixedMode,
  input  logic        defaultNan,
  input  logic [31:0] operand,
  output logic        outValid,
  output logic [31:0] result,
  output logic        flagInvalid,
  output logic        flagDivZero,
  output logic        flagUnderflow
);
  import recip_est_pkg::*;

  strobes_t strobes;

  recip_est_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .fixedMode  (fixedMode),
    .defaultNan (defaultNan),
    .operand    (operand),
    .strobes    (strobes),
    .outValid   (outValid)
  );

  recip_est_dp #(.IDX_BITS(IDX_BITS), .USE_TABLE(USE_TABLE)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .operand       (operand),
    .result        (result),
    .flagInvalid   (flagInvalid),
    .flagDivZero   (flagDivZero),
    .flagUnderflow (flagUnderflow)
  );

endmodule

// File: rtl/recip_est_chk.sv
module recip_est_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        fixedMode,
  input logic        defaultNan,
  input logic [31:0] operand,
  input logic        outValid,
  input logic [31:0] result,
  input logic        flagInvalid,
  input logic        flagDivZero,
  input logic        flagUnderflow
);

  // R1
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_no_spurious_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));
  // R10
  p_one_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flagInvalid, flagDivZero, flagUnderflow}));
  // R8 / R9
  p_fixed_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    inValid && fixedMode |=> !flagInvalid && !flagDivZero && !flagUnderflow);
  // R4
  p_divzero_inf_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid && flagDivZero |-> result[30:0] == 31'h7F80_0000);
  // R3
  p_underflow_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid && flagUnderflow |-> result[30:0] == 31'h0);
  // R7
  p_default_nan_r7: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !fixedMode && defaultNan && operand[30:23] == 8'hFF && operand[22:0] != 23'h0
    |=> result == 32'h7FC0_0000);

endmodule

bind recip_est_unit recip_est_chk u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .inValid       (inValid),
  .fixedMode     (fixedMode),
  .defaultNan    (defaultNan),
  .operand       (operand),
  .outValid      (outValid),
  .result        (result),
  .flagInvalid   (flagInvalid),
  .flagDivZero   (flagDivZero),
  .flagUnderflow (flagUnderflow)
);

// File: tb/tb_recip_est_unit.sv
module tb_recip_est_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        fixedMode = 1'b0;
  logic        defaultNan = 1'b0;
  logic [31:0] operand = '0;
  logic        outValid;
  logic [31:0] result;
  logic        flagInvalid;
  logic        flagDivZero;
  logic        flagUnderflow;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  recip_est_unit dut (
    .clk           (clk),
    .rstN          (rstN),
    .inValid       (inValid),
    .fixedMode     (fixedMode),
    .defaultNan    (defaultNan),
    .operand       (operand),
    .outValid      (outValid),
    .result        (result),
    .flagInvalid   (flagInvalid),
    .flagDivZero   (flagDivZero),
    .flagUnderflow (flagUnderflow)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Midpoint reciprocal estimate, computed with reals.
  function automatic logic [7:0] refEst(int q);
    real r;
    int  s;
    r = 512.0 / (q + 0.5);
    s = $rtoi($floor(256.0 * r + 0.5));
    return s[7:0];
  endfunction

  task automatic check(string req, logic [31:0] expRes, logic [2:0] expFlags);
    logic [2:0] gotFlags;
    gotFlags = {flagInvalid, flagDivZero, flagUnderflow};
    checks++;
    if (outValid !== 1'b1 || result !== expRes || gotFlags !== expFlags) begin
      fails++;
      $display("FAIL %s: op=%h actual v=%b res=%h flags=%b expected v=1 res=%h flags=%b",
               req, operand, outValid, result, gotFlags, expRes, expFlags);
    end
  endtask

  task automatic apply(logic [31:0] op, logic fm, logic dn);
    @(negedge clk);
    inValid = 1'b1; operand = op; fixedMode = fm; defaultNan = dn;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic checkHold(logic [31:0] expRes);
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || result !== expRes) begin
      fails++;
      $display("FAIL R1 hold: actual v=%b res=%h expected v=0 res=%h", outValid, result, expRes);
    end
  endtask

  initial begin
    logic [31:0] exp32;
    logic [7:0]  e8;
    // R11 reset state
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || result !== 32'h0 || {flagInvalid, flagDivZero, flagUnderflow} !== 3'b0) begin
      fails++;
      $display("FAIL R11 in reset: actual v=%b res=%h expected v=0 res=0", outValid, result);
    end
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || result !== 32'h0 || {flagInvalid, flagDivZero, flagUnderflow} !== 3'b0) begin
      fails++;
      $display("FAIL R11 after reset: actual v=%b res=%h expected v=0 res=0", outValid, result);
    end

    // R2 float normals: every index at several exponents and both signs
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: e8 = 8'd1;
        1: e8 = 8'd127;
        2: e8 = 8'd200;
        default: e8 = 8'd252;
      endcase
      for (int i = 0; i < 256; i++) begin
        logic [7:0]  idx8;
        logic [14:0] low;
        logic        sg;
        idx8 = i[7:0];
        low  = 15'(i * 97 + k * 4099);
        sg   = i[0] ^ k[0];
        apply({sg, e8, idx8, low}, 1'b0, 1'b0);
        exp32 = {sg, 8'(8'd253 - e8), refEst(256 + i), 15'h0};
        check("R2 float estimate", exp32, 3'b000);
      end
    end
    checkHold(exp32);

    // R9 fixed with top bit set: every 9-bit prefix
    for (int q = 256; q < 512; q++) begin
      logic [8:0]  q9;
      logic [22:0] low;
      q9  = q[8:0];
      low = 23'(q * 40503);
      apply({q9, low}, 1'b1, q[0]);
      exp32 = {1'b1, refEst(q), 23'h0};
      check("R9 fixed estimate", exp32, 3'b000);
    end
    checkHold(exp32);

    // R8 fixed with top bit clear
    apply(32'h0000_0000, 1'b1, 1'b0); check("R8 fixed zero", 32'hFFFF_FFFF, 3'b000);
    apply(32'h7FFF_FFFF, 1'b1, 1'b0); check("R8 fixed max below half", 32'hFFFF_FFFF, 3'b000);
    apply(32'h4000_0001, 1'b1, 1'b1); check("R8 fixed quarter", 32'hFFFF_FFFF, 3'b000);
    checkHold(32'hFFFF_FFFF);

    // R4 zero and subnormal (flags order {inv,dz,uf})
    apply(32'h0000_0000, 1'b0, 1'b0); check("R4 +zero", 32'h7F80_0000, 3'b010);
    apply(32'h8000_0000, 1'b0, 1'b0); check("R4 -zero", 32'hFF80_0000, 3'b010);
    apply(32'h0012_3456, 1'b0, 1'b1); check("R4 subnormal", 32'h7F80_0000, 3'b010);
    apply(32'h807F_FFFF, 1'b0, 1'b0); check("R4 -subnormal", 32'hFF80_0000, 3'b010);

    // R5 infinities
    apply(32'h7F80_0000, 1'b0, 1'b0); check("R5 +inf", 32'h0000_0000, 3'b000);
    apply(32'hFF80_0000, 1'b0, 1'b1); check("R5 -inf", 32'h8000_0000, 3'b000);

    // R3 huge operands
    apply(32'h7E80_0000, 1'b0, 1'b0); check("R3 exp 253", 32'h0000_0000, 3'b001);
    apply(32'hFF7F_FFFF, 1'b0, 1'b0); check("R3 -exp 254", 32'h8000_0000, 3'b001);
    apply(32'h7E7F_FFFF, 1'b0, 1'b0);
    check("R2 exp 252 edge", {1'b0, 8'd1, refEst(511), 15'h0}, 3'b000);

    // R6 NaN propagation
    apply(32'h7FC1_2345, 1'b0, 1'b0); check("R6 quiet NaN", 32'h7FC1_2345, 3'b000);
    apply(32'h7F80_0001, 1'b0, 1'b0); check("R6 signaling NaN", 32'h7FC0_0001, 3'b100);
    apply(32'hFFA0_0000, 1'b0, 1'b0); check("R6 -signaling NaN", 32'hFFE0_0000, 3'b100);

    // R7 default NaN
    apply(32'hFFC0_0001, 1'b0, 1'b1); check("R7 quiet NaN default", 32'h7FC0_0000, 3'b000);
    apply(32'h7F80_0001, 1'b0, 1'b1); check("R7 signaling NaN default", 32'h7FC0_0000, 3'b100);
    checkHold(32'h7FC0_0000);

    // R10 after a flagged result, a clean one clears the flags
    apply(32'h3F80_0000, 1'b0, 1'b0);
    check("R10 flags clear", {1'b0, 8'd126, refEst(256), 15'h0}, 3'b000);

    // R1 back-to-back operands
    @(negedge clk);
    inValid = 1'b1; fixedMode = 1'b0; defaultNan = 1'b0; operand = 32'h0000_0000;
    @(negedge clk);
    check("R1 back-to-back first", 32'h7F80_0000, 3'b010);
    operand = 32'h7F80_0000;
    @(negedge clk);
    inValid = 1'b0;
    check("R1 back-to-back second", 32'h0000_0000, 3'b000);
    checkHold(32'h0000_0000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule